// File: doc/BRIEF.md
# Address-Range Second-Level Cache Maintenance Engine

This block walks a shared second-level cache and brings it into step with memory over a chosen physical address range, or over the whole cache. Software first sets the operation in a control register, then loads the range limit into an end register, and finally writes a start register; that last write is the trigger. The engine then steps one cache line at a time from the start line up to and including the line that holds the end address, probing the tag array for each line.

For every line the probe reports whether the line is present and whether it is dirty. Depending on the chosen operation the engine writes dirty lines back through a request/acknowledge handshake, drops lines from the cache, or both. A busy flag in the control register stays high for the whole run. A separate trigger register starts a sweep over every set of the cache instead of a range; that sweep either discards lines or writes them back and drops them, depending on the invalidate-mode bit.

The line size is selected at run time between 128 and 64 bytes. A trigger that arrives while a run is in progress is dropped and recorded in a sticky error flag, so the run in progress is never disturbed.

Top module: `l2_range_maint`

## Requirements
- R1: Control register layout (read back on `ctrl_rdata`): bit 0 lookup disable, bit 1 invalidate mode (IM), bit 4 line-size select (0 = 128-byte lines, 1 = 64-byte lines), bit 7 sticky error (read only), bit 8 busy (read only), bits 11:9 region operation. Every bit reads 0 after reset. Register select: 0 control, 1 range end, 2 range start, 3 whole-cache trigger.
- R2: A write to the start register while idle sets busy on the next cycle and processes every line from the line holding the start address to the line holding the end address, inclusive; address bits below the line size are ignored in both registers.
- R3: Region operation 000 (and any value other than 001) is a flush: present dirty lines are written back and stay present, now clean; clean and absent lines are unchanged.
- R4: Region operation 001 with IM = 0 is a discard: present lines in range are dropped and no write-back is issued.
- R5: Region operation 001 with IM = 1 is flush-then-invalidate: present dirty lines are written back and then dropped; present clean lines are dropped.
- R6: Writing a 1 in bit 0 to the whole-cache trigger sweeps every set, probing address set × line size; with IM = 1 it writes back dirty lines and drops all present lines, with IM = 0 it drops them without write-back.
- R7: A line that needs no write-back takes exactly one cycle, so a run of N lines with no write-back keeps busy high for exactly N cycles.
- R8: A write-back request stays asserted with a stable address until it is acknowledged, and is only raised while busy.
- R9: A start or whole-cache trigger written while busy is ignored and sets the sticky error bit; a control write with bit 7 set clears it.
- R10: The disable bit drives `lookup_bypass` and does not stop range or whole-cache operations.
- R11: With 64-byte lines, line numbers and probe addresses use address bit 6 upward.
- R12: If the end address lies in a line below the start line, only the start line is processed.
- R13: Operation, IM and line size are captured at launch; control writes during a run do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 end, 2 start, 3 whole-cache trigger |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read-back including busy and error |
| lookup_bypass | output | 1 | Normal lookups bypassed (disable bit) |
| probe_valid | output | 1 | Tag probe issued for `probe_addr` |
| probe_addr | output | 32 | Line-aligned address being processed |
| probe_hit | input | 1 | Probed line is present |
| probe_dirty | input | 1 | Probed line is dirty |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Write-back line address |
| wb_ack | input | 1 | Write-back accepted |
| inv_valid | output | 1 | Drop the line at `inv_addr` this cycle |
| inv_addr | output | 32 | Address of the line to drop |

## Verification
The checker watches, on every cycle, that write-back requests and line drops only happen while busy, that a pending write-back holds its address until acknowledged, that a trigger during a run raises the error flag and that the flag stays set until cleared. What each operation leaves in the tag array, the inclusive line span, the one-line-per-cycle pace, the 64-byte line mode, the reversed-range case and the whole-cache sweep can only be shown by the bench's scenarios, which compare a tag-array model after each run with a prediction and count busy cycles and write-backs.

// File: rtl/l2rm_pkg.sv
package l2rm_pkg;
    localparam int DW = 32;

    localparam int B_DIS  = 0;
    localparam int B_IM   = 1;
    localparam int B_LSZ  = 4;
    localparam int B_ERR  = 7;
    localparam int B_BUSY = 8;
    localparam int B_OPLO = 9;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_END   = 2'd1,
        SEL_START = 2'd2,
        SEL_WHOLE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_FLUSH = 2'd0,
        ACT_DROP  = 2'd1,
        ACT_FDROP = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WB    = 2'd2
    } step_e;

    typedef struct packed {
        logic [2:0] rop;
        logic       lsz;
        logic       im;
        logic       dis;
    } ctrl_t;

    function automatic act_e pick_act(input logic [2:0] rop, input logic im,
                                      input logic whole);
        if (whole || rop == 3'b001)
            return im ? ACT_FDROP : ACT_DROP;
        return ACT_FLUSH;
    endfunction

    function automatic logic [2:0] line_shift(input logic lsz);
        return lsz ? 3'd6 : 3'd7;
    endfunction
endpackage

// File: rtl/l2rm_regs.sv
module l2rm_regs
    import l2rm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          busy,
    output ctrl_t         ctrl,
    output logic          err,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic          go_range,
    output logic          go_whole
);
    logic hit_start, hit_whole, hit_ctrl;

    assign hit_ctrl  = reg_we && reg_sel_e'(reg_sel) == SEL_CTRL;
    assign hit_start = reg_we && reg_sel_e'(reg_sel) == SEL_START;
    assign hit_whole = reg_we && reg_sel_e'(reg_sel) == SEL_WHOLE && reg_wdata[0];

    assign go_range = hit_start && !busy;
    assign go_whole = hit_whole && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            err        <= 1'b0;
            start_addr <= '0;
            end_addr   <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl.rop <= reg_wdata[B_OPLO+2:B_OPLO];
                ctrl.lsz <= reg_wdata[B_LSZ];
                ctrl.im  <= reg_wdata[B_IM];
                ctrl.dis <= reg_wdata[B_DIS];
            end
            if (reg_we && reg_sel_e'(reg_sel) == SEL_END)
                end_addr <= reg_wdata[AW-1:0];
            if (go_range)
                start_addr <= reg_wdata[AW-1:0];
            if ((hit_start || hit_whole) && busy)
                err <= 1'b1;
            else if (hit_ctrl && reg_wdata[B_ERR])
                err <= 1'b0;
        end
    end
endmodule

// File: rtl/l2rm_stepper.sv
module l2rm_stepper
    import l2rm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SETS = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_range,
    input  logic          go_whole,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  ctrl_t         ctrl,
    input  logic          probe_hit,
    input  logic          probe_dirty,
    input  logic          wb_ack,
    output logic          busy,
    output logic          probe_valid,
    output logic [AW-1:0] line_addr,
    output logic          wb_req,
    output logic          inv_valid
);
    step_e         st;
    act_e          act_q;
    logic [2:0]    sh_q;
    logic [AW-1:0] cur_line, last_line;
    logic [AW-1:0] first_n, last_n;
    logic [2:0]    sh_n;
    logic          need_wb, need_drop, advance;

    // Launch decode: start line comes straight from the write data.
    assign sh_n    = line_shift(ctrl.lsz);
    assign first_n = go_whole ? '0 : (start_addr >> sh_n);
    assign last_n  = go_whole ? AW'(SETS - 1)
                   : (((end_addr >> sh_n) < first_n) ? first_n : (end_addr >> sh_n));

    assign need_wb   = probe_hit && probe_dirty && act_q != ACT_DROP;
    assign need_drop = probe_hit && act_q != ACT_FLUSH;

    always_comb begin
        advance   = 1'b0;
        inv_valid = 1'b0;
        case (st)
            ST_PROBE: if (!need_wb) begin
                advance   = 1'b1;
                inv_valid = need_drop;
            end
            ST_WB: if (wb_ack) begin
                advance   = 1'b1;
                inv_valid = act_q != ACT_FLUSH;
            end
            default: ;
        endcase
    end

    assign busy        = st != ST_IDLE;
    assign probe_valid = st == ST_PROBE;
    assign wb_req      = st == ST_WB;
    assign line_addr   = cur_line << sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            act_q     <= ACT_FLUSH;
            sh_q      <= 3'd7;
            cur_line  <= '0;
            last_line <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go_range || go_whole) begin
                    st        <= ST_PROBE;
                    act_q     <= pick_act(ctrl.rop, ctrl.im, go_whole);
                    sh_q      <= sh_n;
                    cur_line  <= first_n;
                    last_line <= last_n;
                end
                ST_PROBE: if (need_wb) st <= ST_WB;
                default: ;
            endcase
            if (advance) begin
                if (cur_line >= last_line) begin
                    st <= ST_IDLE;
                end else begin
                    st       <= ST_PROBE;
                    cur_line <= cur_line + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/l2_range_maint.sv
module l2_range_maint
    import l2rm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SETS = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   ctrl_rdata,
    output logic          lookup_bypass,
    output logic          probe_valid,
    output logic [AW-1:0] probe_addr,
    input  logic          probe_hit,
    input  logic          probe_dirty,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    input  logic          wb_ack,
    output logic          inv_valid,
    output logic [AW-1:0] inv_addr
);
    ctrl_t         ctrl;
    logic          err, busy, go_range, go_whole;
    logic [AW-1:0] start_addr, end_addr, line_addr;

    l2rm_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .ctrl(ctrl), .err(err),
        .start_addr(start_addr), .end_addr(end_addr),
        .go_range(go_range), .go_whole(go_whole)
    );

    // Start address is taken from the write data in the launch cycle.
    l2rm_stepper #(.AW(AW), .SETS(SETS)) u_step (
        .clk(clk), .rst(rst), .go_range(go_range), .go_whole(go_whole),
        .start_addr(go_range ? reg_wdata[AW-1:0] : start_addr),
        .end_addr(end_addr), .ctrl(ctrl),
        .probe_hit(probe_hit), .probe_dirty(probe_dirty), .wb_ack(wb_ack),
        .busy(busy), .probe_valid(probe_valid), .line_addr(line_addr),
        .wb_req(wb_req), .inv_valid(inv_valid)
    );

    always_comb begin
        ctrl_rdata                    = '0;
        ctrl_rdata[B_DIS]             = ctrl.dis;
        ctrl_rdata[B_IM]              = ctrl.im;
        ctrl_rdata[B_LSZ]             = ctrl.lsz;
        ctrl_rdata[B_ERR]             = err;
        ctrl_rdata[B_BUSY]            = busy;
        ctrl_rdata[B_OPLO+2:B_OPLO]   = ctrl.rop;
    end

    assign lookup_bypass = ctrl.dis;
    assign probe_addr    = line_addr;
    assign wb_addr       = line_addr;
    assign inv_addr      = line_addr;
endmodule

// File: rtl/l2rm_checker.sv
module l2rm_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [1:0]    reg_sel,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   ctrl_rdata,
    input logic          wb_req,
    input logic [AW-1:0] wb_addr,
    input logic          wb_ack,
    input logic          inv_valid
);
    logic busy, err, trig_wr, clr_wr;
    assign busy    = ctrl_rdata[8];
    assign err     = ctrl_rdata[7];
    assign trig_wr = reg_we && (reg_sel == 2'd2 || (reg_sel == 2'd3 && reg_wdata[0]));
    assign clr_wr  = reg_we && reg_sel == 2'd0 && reg_wdata[7];

    p_wb_in_run_r8: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> busy);

    p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

    p_drop_in_run_r4: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> busy);

    p_trig_busy_err_r9: assert property (@(posedge clk) disable iff (rst)
        busy && trig_wr |=> err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err && !clr_wr |=> err);

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (rst)
        !busy && trig_wr |=> busy);
endmodule

bind l2_range_maint l2rm_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .inv_valid(inv_valid)
);

// File: tb/tb_l2_range_maint.sv
module tb_l2_range_maint;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   ctrl_rdata;
    logic          lookup_bypass, probe_valid, probe_hit, probe_dirty;
    logic          wb_req, wb_ack, inv_valid;
    logic [AW-1:0] probe_addr, wb_addr, inv_addr;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    l2_range_maint #(.AW(AW), .SETS(64)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata),
        .lookup_bypass(lookup_bypass), .probe_valid(probe_valid),
        .probe_addr(probe_addr), .probe_hit(probe_hit),
        .probe_dirty(probe_dirty), .wb_req(wb_req), .wb_addr(wb_addr),
        .wb_ack(wb_ack), .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    // Tag-array model (64 lines, index = address >> line shift).
    logic [63:0] m_v = '0, m_d = '0;
    logic [63:0] ld_v = '0, ld_d = '0;
    bit          ld_tog = 0, ld_seen = 0;
    int          wb_cnt = 0;
    int          sh = 7;

    assign probe_hit   = m_v[6'(probe_addr >> sh)];
    assign probe_dirty = m_d[6'(probe_addr >> sh)];

    always @(posedge clk) begin
        if (ld_tog != ld_seen) begin
            m_v     <= ld_v;
            m_d     <= ld_d;
            ld_seen <= ld_tog;
        end else begin
            if (wb_req && wb_ack) begin
                m_d[6'(wb_addr >> sh)] <= 1'b0;
                wb_cnt <= wb_cnt + 1;
            end
            if (inv_valid) begin
                m_v[6'(inv_addr >> sh)] <= 1'b0;
                m_d[6'(inv_addr >> sh)] <= 1'b0;
            end
        end
    end

    int ack_dly = 0;
    initial wb_ack = 1'b0;
    always @(negedge clk) begin
        if (wb_req && !wb_ack) begin
            if (ack_dly == 2) begin wb_ack <= 1'b1; ack_dly <= 0; end
            else ack_dly <= ack_dly + 1;
        end else begin
            wb_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [63:0] v, input logic [63:0] d);
        ld_v = v; ld_d = d & v; ld_tog = ~ld_tog;
        @(negedge clk);
    endtask

    task automatic rand_load();
        logic [63:0] v, d;
        v = {$urandom, $urandom};
        d = {$urandom, $urandom};
        load(v, d);
    endtask

    task automatic set_ctrl(input logic [2:0] rop, input bit im, input bit lsz, input bit dis);
        logic [31:0] c;
        c = '0; c[11:9] = rop; c[1] = im; c[4] = lsz; c[0] = dis;
        sh = lsz ? 6 : 7;
        wr(0, c);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (ctrl_rdata[8]) begin cyc++; @(negedge clk); end
    endtask

    // Prediction: act 0 flush, 1 drop, 2 flush+drop.
    logic [63:0] e_v, e_d;
    int          e_wb;
    task automatic predict(input int first, input int last, input int act);
        e_v = m_v; e_d = m_d; e_wb = 0;
        for (int i = first; i <= last; i++) begin
            if (e_v[i]) begin
                if (e_d[i] && act != 1) e_wb++;
                if (act == 0) e_d[i] = 1'b0;
                else begin e_v[i] = 1'b0; e_d[i] = 1'b0; end
            end
        end
    endtask

    task automatic check_state(input string req, input int wb0);
        chk(m_v == e_v, {req, " valid"}, m_v, e_v);
        chk(m_d == e_d, {req, " dirty"}, m_d, e_d);
        chk(wb_cnt - wb0 == e_wb, {req, " wbcount"}, wb_cnt - wb0, e_wb);
    endtask

    task automatic run_range(input string req, input int sl, input int el, input int act,
                             input int lowbits_s, input int lowbits_e, output int cyc);
        int wb0;
        int last;
        last = (el < sl) ? sl : el;
        predict(sl, last, act);
        wb0 = wb_cnt;
        wr(1, 32'((el << sh) | lowbits_e));
        wr(2, 32'((sl << sh) | lowbits_s));
        wait_idle(cyc);
        check_state(req, wb0);
    endtask

    int cyc;

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        chk(ctrl_rdata == 32'h0, "R1 reset ctrl", ctrl_rdata, 0);
        chk(!wb_req && !probe_valid && !inv_valid, "R1 reset outputs", {wb_req, probe_valid, inv_valid}, 0);

        // R1 layout readback
        set_ctrl(3'b101, 1, 1, 1);
        chk(ctrl_rdata == 32'h0A13, "R1 ctrl layout", ctrl_rdata, 32'h0A13);

        // R2/R3: flush lines 4..9 with low bits set
        set_ctrl(3'b000, 0, 0, 0);
        rand_load();
        run_range("R3 flush", 4, 9, 0, 'h05, 'h7F, cyc);
        chk(cyc >= 6, "R2 span busy", cyc, 6);

        // R3: other op code acts as flush
        set_ctrl(3'b110, 1, 0, 0);
        rand_load();
        run_range("R3 other-code flush", 20, 27, 0, 0, 3, cyc);

        // R4 + R7: discard, exact cycle count
        set_ctrl(3'b001, 0, 0, 0);
        rand_load();
        run_range("R4 discard", 10, 21, 1, 0, 0, cyc);
        chk(cyc == 12, "R7 one line per cycle", cyc, 12);

        // R5 flush+drop
        set_ctrl(3'b001, 1, 0, 0);
        rand_load();
        run_range("R5 flush-drop", 30, 40, 2, 1, 2, cyc);

        // R7 clean flush run
        set_ctrl(3'b000, 0, 0, 0);
        load(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        run_range("R7 clean flush", 0, 7, 0, 0, 0, cyc);
        chk(cyc == 8, "R7 clean flush cycles", cyc, 8);

        // R11 64-byte lines: 0x100..0x17F -> lines 4,5
        set_ctrl(3'b001, 0, 1, 0);
        rand_load();
        run_range("R11 64B lines", 4, 5, 1, 'h00, 'h3F, cyc);
        chk(cyc == 2, "R11 64B line count", cyc, 2);

        // R12 end below start
        set_ctrl(3'b001, 0, 0, 0);
        rand_load();
        run_range("R12 reversed range", 10, 3, 1, 0, 0, cyc);
        chk(cyc == 1, "R12 single line", cyc, 1);

        // R9 + R13: trigger and control write during busy
        begin
            int wb0;
            set_ctrl(3'b001, 1, 0, 0);
            load(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
            predict(0, 15, 2);
            wb0 = wb_cnt;
            wr(1, 32'(15 << 7));
            wr(2, 32'(0));
            wr(2, 32'(40 << 7));
            chk(ctrl_rdata[7] == 1'b1, "R9 error on busy start", ctrl_rdata[7], 1);
            wr(0, 32'h0);
            wr(3, 32'h1);
            wait_idle(cyc);
            check_state("R9 R13 run unchanged", wb0);
            chk(ctrl_rdata[7] == 1'b1, "R9 error sticky", ctrl_rdata[7], 1);
            wr(0, 32'h80);
            chk(ctrl_rdata[7] == 1'b0, "R9 error cleared", ctrl_rdata[7], 0);
        end

        // R6 whole-cache sweeps
        begin
            int wb0;
            set_ctrl(3'b000, 1, 0, 0);
            rand_load();
            predict(0, 63, 2);
            wb0 = wb_cnt;
            wr(3, 32'h1);
            wait_idle(cyc);
            check_state("R6 whole IM1", wb0);
            set_ctrl(3'b000, 0, 1, 0);
            rand_load();
            predict(0, 63, 1);
            wb0 = wb_cnt;
            wr(3, 32'h1);
            wait_idle(cyc);
            check_state("R6 whole IM0", wb0);
            chk(cyc == 64, "R6 whole sweep length", cyc, 64);
            wr(3, 32'h0);
            chk(ctrl_rdata[8] == 1'b0, "R6 trigger bit0 clear no run", ctrl_rdata[8], 0);
        end

        // R10 disable
        set_ctrl(3'b001, 1, 0, 1);
        chk(lookup_bypass == 1'b1, "R10 bypass out", lookup_bypass, 1);
        rand_load();
        run_range("R10 op while disabled", 50, 60, 2, 0, 0, cyc);

        // Random mix
        for (int k = 0; k < 24; k++) begin
            int s, e, a, lz;
            logic [2:0] rop;
            bit im;
            rop = 3'($urandom % 3);
            im  = 1'($urandom % 2);
            lz  = $urandom % 2;
            a   = (rop == 3'b001) ? (im ? 2 : 1) : 0;
            set_ctrl(rop, im, 1'(lz), 0);
            rand_load();
            s = $urandom % 64;
            e = s + ($urandom % 12);
            if (e > 63) e = 63;
            run_range("R2 R3 R4 R5 random", s, e, a, $urandom % 32, $urandom % 32, cyc);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule